// File: doc/BRIEF.md
# Sprite Memory Block Copier with CPU Stall

This block copies one page of CPU memory into a 256-byte sprite attribute memory. The CPU starts it by writing a page number to a trigger register. The byte written becomes the high byte of the source address, so a value of 7 selects the page at 0x0700. From the next CPU cycle on, the block holds the CPU off the bus with a stall output. It then masters the bus itself and moves the page one byte at a time into the sprite memory.

The block keeps its own parity bit for CPU cycles. That bit toggles on every CPU cycle enable from reset. At the trigger, the block uses it to insert one or two idle alignment cycles, so the CPU always comes back on an odd cycle. Each byte then takes two CPU cycles: one bus read of `{page, index}`, followed by one sprite memory write at the same index. Clock cycles where the cycle enable is low have no effect on the transfer.

Top module: `sprite_dma`

## Requirements
- R1: While reset is asserted and after it is released with no trigger, `cpuStall`, `busRdEn` and `sprWrEn` are all low.
- R2: A trigger is a CPU cycle with `cycEn` high, `regWrEn` high and `regAddr` equal to 0x4014. Every bus read of the transfer then addresses `{regWrData, index}`, with `regWrData` in bits 15:8 and the index in bits 7:0.
- R3: CPU cycles are numbered from 0 at the first `cycEn` after reset. A trigger in an odd-numbered cycle keeps `cpuStall` high for exactly 513 CPU cycles.
- R4: A trigger in an even-numbered cycle keeps `cpuStall` high for exactly 514 CPU cycles.
- R5: The first CPU cycle with `cpuStall` low after a transfer is always odd-numbered.
- R6: After the one or two alignment cycles (no read, no write), the transfer runs 256 pairs. Each pair is a read cycle (`busRdEn` high) followed by a write cycle, and the index climbs from 0x00 to 0xFF.
- R7: The byte on `busRdData` in a read cycle is written to sprite index `sprWrAddr` equal to that read's address bits 7:0, during the following cycle. `sprWrEn` is high for exactly one clock, the one where `cycEn` is high.
- R8: `cpuStall` rises in the CPU cycle after the trigger and stays high without a gap until the last write cycle ends.
- R9: A trigger-address write while a transfer is running is ignored: the page, the order and the stall length stay unchanged.
- R10: Writes to any other address, and trigger-address writes in a clock without `cycEn`, start nothing.
- R11: In clocks with `cycEn` low, the transfer state does not advance and `sprWrEn` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cycEn | input | 1 | One-clock strobe marking the end of each CPU cycle |
| regWrEn | input | 1 | CPU register write strobe |
| regAddr | input | 16 | CPU register write address |
| regWrData | input | 8 | CPU register write data (source page) |
| busRdEn | output | 1 | Block is reading the bus in this CPU cycle |
| busRdAddr | output | 16 | Bus read address `{page, index}` |
| busRdData | input | 8 | Bus read data, valid during the read cycle |
| sprWrEn | output | 1 | Sprite memory write strobe |
| sprWrAddr | output | 8 | Sprite memory write index |
| sprWrData | output | 8 | Sprite memory write data |
| cpuStall | output | 1 | Holds the CPU off the bus |

## Verification
The assertions assume that `busRdData` is a settled function of `busRdAddr` by the `cycEn` clock that ends a read cycle. They also assume that `cycEn` is a one-clock strobe, so the block sees each CPU cycle exactly once. The bench drives read data combinationally from the address, through a fixed byte function of page and index. It generates `cycEn` with zero, one or two idle clocks between strobes, so the same transfer runs under several cycle-enable spacings. Triggers are placed deliberately on even and odd cycles, and one is placed inside a running transfer.

// File: rtl/sprite_dma_pkg.sv
package sprite_dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ALIGN = 2'd1,
    ST_READ  = 2'd2,
    ST_WRITE = 2'd3
  } dmaState_t;

  typedef struct packed {
    logic loadPage;
    logic rdCycle;
    logic wrCycle;
    logic advance;
  } dmaStrb_t;

endpackage

// File: rtl/sprite_dma_ctrl.sv
module sprite_dma_ctrl
  import sprite_dma_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     cycEn,
  input  logic     trigHit,
  input  logic     lastIdx,
  output dmaStrb_t strb,
  output logic     cpuStall
);

  localparam int PAIRS    = 1 << IDX_W;
  localparam int LEN_ODD  = 2 * PAIRS + 1;
  localparam int LEN_EVEN = 2 * PAIRS + 2;
  localparam int CNT_W    = $clog2(LEN_EVEN + 1);

  dmaState_t state;
  logic      cycOdd;
  logic      needTwo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycOdd <= 1'b0;
    end else if (cycEn) begin
      cycOdd <= ~cycOdd;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      needTwo <= 1'b0;
    end else if (cycEn) begin
      case (state)
        ST_IDLE: begin
          if (trigHit) begin
            state   <= ST_ALIGN;
            needTwo <= ~cycOdd;
          end
        end
        ST_ALIGN: begin
          if (needTwo) begin
            needTwo <= 1'b0;
          end else begin
            state <= ST_READ;
          end
        end
        ST_READ:  state <= ST_WRITE;
        ST_WRITE: state <= lastIdx ? ST_IDLE : ST_READ;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.loadPage = (state == ST_IDLE) && trigHit && cycEn;
    strb.rdCycle  = (state == ST_READ);
    strb.wrCycle  = (state == ST_WRITE);
    strb.advance  = (state == ST_WRITE) && cycEn;
  end

  assign cpuStall = (state != ST_IDLE);

  // Checker state: stalled CPU cycles since the accepted trigger
  logic [CNT_W-1:0] stallCnt;
  logic             trigOddSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stallCnt    <= '0;
      trigOddSeen <= 1'b0;
    end else if (cycEn) begin
      if ((state == ST_IDLE) && trigHit) begin
        stallCnt    <= '0;
        trigOddSeen <= cycOdd;
      end else if (cpuStall) begin
        stallCnt <= stallCnt + 1'b1;
      end
    end
  end

  // R3
  stall_odd_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(cpuStall) && trigOddSeen) |-> (stallCnt == CNT_W'(LEN_ODD)));

  // R4
  stall_even_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(cpuStall) && !trigOddSeen) |-> (stallCnt == CNT_W'(LEN_EVEN)));

  // R5
  resume_odd_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cpuStall) |-> cycOdd);

  // R8
  stall_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuStall && !cycEn) |=> cpuStall);

  // R11
  state_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cycEn |=> $stable(state));

endmodule

// File: rtl/sprite_dma_path.sv
module sprite_dma_path
  import sprite_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cycEn,
  input  dmaStrb_t                strb,
  input  logic [ADDR_W-IDX_W-1:0] pageIn,
  input  logic [DATA_W-1:0]       busRdData,
  output logic [ADDR_W-1:0]       busRdAddr,
  output logic                    busRdEn,
  output logic                    sprWrEn,
  output logic [IDX_W-1:0]        sprWrAddr,
  output logic [DATA_W-1:0]       sprWrData,
  output logic                    lastIdx
);

  localparam int PAGE_W = ADDR_W - IDX_W;

  logic [PAGE_W-1:0] pageReg;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] dataLatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageReg <= '0;
      idx     <= '0;
    end else if (strb.loadPage) begin
      pageReg <= pageIn;
      idx     <= '0;
    end else if (strb.advance) begin
      idx <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataLatch <= '0;
    end else if (strb.rdCycle && cycEn) begin
      dataLatch <= busRdData;
    end
  end

  assign busRdAddr = {pageReg, idx};
  assign busRdEn   = strb.rdCycle;
  assign sprWrEn   = strb.wrCycle && cycEn;
  assign sprWrAddr = idx;
  assign sprWrData = dataLatch;
  assign lastIdx   = &idx;

  // R7
  latch_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdCycle && cycEn) |=> (sprWrData == $past(busRdData)));

  // R6
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdCycle && cycEn) |=>
      (strb.wrCycle && (sprWrAddr == $past(busRdAddr[IDX_W-1:0]))));

endmodule

// File: rtl/sprite_dma.sv
module sprite_dma
  import sprite_dma_pkg::*;
#(
  parameter int             ADDR_W    = 16,
  parameter int             IDX_W     = 8,
  parameter int             DATA_W    = 8,
  parameter logic [15:0]    TRIG_ADDR = 16'h4014
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycEn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic              busRdEn,
  output logic [ADDR_W-1:0] busRdAddr,
  input  logic [DATA_W-1:0] busRdData,
  output logic              sprWrEn,
  output logic [IDX_W-1:0]  sprWrAddr,
  output logic [DATA_W-1:0] sprWrData,
  output logic              cpuStall
);

  localparam int PAGE_W = ADDR_W - IDX_W;

  dmaStrb_t strb;
  logic     trigHit;
  logic     lastIdx;

  assign trigHit = regWrEn && (regAddr == ADDR_W'(TRIG_ADDR));

  sprite_dma_ctrl #(
    .IDX_W (IDX_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cycEn    (cycEn),
    .trigHit  (trigHit),
    .lastIdx  (lastIdx),
    .strb     (strb),
    .cpuStall (cpuStall)
  );

  sprite_dma_path #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .DATA_W (DATA_W)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .cycEn     (cycEn),
    .strb      (strb),
    .pageIn    (regWrData[PAGE_W-1:0]),
    .busRdData (busRdData),
    .busRdAddr (busRdAddr),
    .busRdEn   (busRdEn),
    .sprWrEn   (sprWrEn),
    .sprWrAddr (sprWrAddr),
    .sprWrData (sprWrData),
    .lastIdx   (lastIdx)
  );

  // R9
  busy_trig_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuStall && trigHit && cycEn) |=> $stable(busRdAddr[ADDR_W-1:IDX_W]));

endmodule

// File: tb/sprite_dma_bench.sv
module sprite_dma_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cycEn = 1'b0;
  logic        regWrEn = 1'b0;
  logic [15:0] regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic        busRdEn;
  logic [15:0] busRdAddr;
  logic [7:0]  busRdData;
  logic        sprWrEn;
  logic [7:0]  sprWrAddr;
  logic [7:0]  sprWrData;
  logic        cpuStall;

  always #2 clk = ~clk;

  function automatic logic [7:0] srcByte(input logic [7:0] p, input logic [7:0] i);
    logic [7:0] r;
    r = (i * 8'd7) + (p * 8'd13) + 8'h5A;
    return r;
  endfunction

  assign busRdData = srcByte(busRdAddr[15:8], busRdAddr[7:0]);

  sprite_dma u_sprite_dma (
    .clk       (clk),
    .rstN      (rstN),
    .cycEn     (cycEn),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .busRdEn   (busRdEn),
    .busRdAddr (busRdAddr),
    .busRdData (busRdData),
    .sprWrEn   (sprWrEn),
    .sprWrAddr (sprWrAddr),
    .sprWrData (sprWrData),
    .cpuStall  (cpuStall)
  );

  logic [7:0] sprMem [256];
  always @(posedge clk) if (sprWrEn) sprMem[sprWrAddr] <= sprWrData;

  int  checks = 0;
  int  failures = 0;
  bit  done = 0;

  // reference model state
  int         cycNum = 0;
  bit         mActive = 0;
  int         mTrig = 0;
  int         mLen = 0;
  logic [7:0] mPage = '0;
  int         stallSeen = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic evaluate(input int c, input bit en);
    bit expStall, expRd, expWr;
    int off, j, i, a;
    expStall = 0; expRd = 0; expWr = 0; i = 0;
    if (mActive && c == mTrig + mLen + 1) begin
      bit memOk;
      memOk = 1;
      check(stallSeen == mLen, (mTrig % 2) ? "R3" : "R4", "stall length",
            stallSeen, mLen);
      check((c % 2) == 1, "R5", "resume cycle parity", c % 2, 1);
      for (int k = 0; k < 256; k++)
        if (sprMem[k] != srcByte(mPage, 8'(k))) memOk = 0;
      check(memOk, "R7", "sprite memory matches page", int'(memOk), 1);
      mActive = 0;
    end
    if (mActive && c > mTrig && c <= mTrig + mLen) begin
      expStall = 1;
      a = mLen - 512;
      off = c - mTrig - 1;
      if (off >= a) begin
        j = off - a;
        i = j / 2;
        expRd = (j % 2) == 0;
        expWr = (j % 2) == 1;
      end
    end
    check(cpuStall == expStall, "R8", "cpuStall", int'(cpuStall), int'(expStall));
    check(busRdEn == expRd, "R6", "busRdEn", int'(busRdEn), int'(expRd));
    if (expRd)
      check(busRdAddr == {mPage, 8'(i)}, "R2", "busRdAddr", int'(busRdAddr),
            int'({mPage, 8'(i)}));
    check(sprWrEn == (expWr && en), en ? "R7" : "R11", "sprWrEn",
          int'(sprWrEn), int'(expWr && en));
    if (expWr && en) begin
      check(sprWrAddr == 8'(i), "R6", "sprWrAddr", int'(sprWrAddr), i);
      check(sprWrData == srcByte(mPage, 8'(i)), "R7", "sprWrData",
            int'(sprWrData), int'(srcByte(mPage, 8'(i))));
    end
    if (en && cpuStall) stallSeen++;
  endtask

  task automatic doCycle(input bit w, input logic [15:0] addr,
                         input logic [7:0] data, input int gap);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      cycEn = 0; regWrEn = 0;
      #1;
      evaluate(cycNum, 0);
    end
    @(negedge clk);
    cycEn = 1; regWrEn = w; regAddr = addr; regWrData = data;
    #1;
    evaluate(cycNum, 1);
    if (w && addr == 16'h4014 && !mActive) begin
      mActive = 1; mTrig = cycNum; mLen = (cycNum % 2) ? 513 : 514;
      mPage = data; stallSeen = 0;
    end
    cycNum++;
  endtask

  task automatic runCycles(input int n, input int gap);
    for (int k = 0; k < n; k++) doCycle(0, 16'h0000, 8'h00, gap);
  endtask

  task automatic idleTrigWrite();
    @(negedge clk);
    cycEn = 0; regWrEn = 1; regAddr = 16'h4014; regWrData = 8'h55;
    #1;
    evaluate(cycNum, 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    for (int k = 0; k < 256; k++) sprMem[k] = 8'h00;
    repeat (3) @(negedge clk);
    cycEn = 1;
    #1;
    // R1: outputs quiet during reset
    check(!cpuStall && !busRdEn && !sprWrEn, "R1", "outputs in reset",
          int'({cpuStall, busRdEn, sprWrEn}), 0);
    @(negedge clk);
    cycEn = 0;
    rstN = 1;
    runCycles(3, 0);
    // R10: trigger address without cycEn, then a foreign address
    idleTrigWrite();
    runCycles(2, 0);
    doCycle(1, 16'h2006, 8'h05, 0);
    runCycles(3, 0);
    check(!cpuStall, "R10", "no stall after ignored writes", int'(cpuStall), 0);
    // R4: even-cycle trigger, back-to-back cycle enables
    if (cycNum % 2) runCycles(1, 0);
    doCycle(1, 16'h4014, 8'h07, 0);
    runCycles(100, 0);
    // R9: trigger during transfer is ignored
    doCycle(1, 16'h4014, 8'h3C, 0);
    runCycles(450, 0);
    // R3: odd-cycle trigger, sparse cycle enables
    if (!(cycNum % 2)) runCycles(1, 2);
    doCycle(1, 16'h4014, 8'h12, 2);
    runCycles(530, 2);
    // R4 again with one idle clock between cycles, top page
    if (cycNum % 2) runCycles(1, 1);
    doCycle(1, 16'h4014, 8'hFF, 1);
    runCycles(530, 1);
    // R3 once more on the zero page
    if (!(cycNum % 2)) runCycles(1, 0);
    doCycle(1, 16'h4014, 8'h00, 0);
    runCycles(520, 0);
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

endmodule